// File: doc/BRIEF.md
# Pipelined Odd-Even Merge Sorter

This block sorts a fixed-size set of N = 2^P unsigned keys, each W bits wide. A whole set arrives in one packed vector together with a valid flag, and a new set may be offered on every clock. The keys pass through a network of compare-exchange elements laid out by recursively merging sorted halves. Each comparator puts the smaller key on the lower-indexed wire and the larger on the higher-indexed wire. Comparators that share a level touch disjoint wire pairs, so they all act in the same cycle.

A register follows every comparator level. The sorted set therefore leaves exactly P(P+1)/2 cycles after it entered, and the valid flag travels through the same stages beside the data. The block has no backpressure. A downstream consumer must take each result in the cycle it appears.

Top module: `oe_merge_sorter`

## Requirements
- R1: Whenever `out_valid` is high, the output items are in non-decreasing order from item 0 to item N-1.
- R2: Each output set holds exactly the same multiset of keys as the input set it came from: no key is lost, added or altered.
- R3: A set presented with `in_valid` high at a rising edge appears on `out_keys` with `out_valid` high exactly P(P+1)/2 rising edges later (6 for P=3).
- R4: A new set is accepted on every clock. Back-to-back sets come out on consecutive cycles, each with the latency of R3.
- R5: A synchronous reset (`rst` high at a rising edge) clears every in-flight valid flag. `out_valid` is low after that edge, and sets that were in flight never appear. The key registers are not cleared.
- R6: Item i of a packed vector occupies bits [(N-1-i)*W +: W], so item 0 is the most significant W bits on both input and output.
- R7: Repeated keys and the extreme values 0 and 2^W-1 are sorted correctly, and ties keep their values.
- R8: A cycle with `in_valid` low yields a cycle with `out_valid` low after the same latency, so idle gaps are preserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the valid pipeline, active high |
| in_valid | input | 1 | Marks `in_keys` as a set to sort this cycle |
| in_keys | input | N*W | Packed unsorted keys, item 0 in the top W bits |
| out_valid | output | 1 | Marks `out_keys` as a sorted result |
| out_keys | output | N*W | Packed ascending keys, item 0 (smallest) in the top W bits |

## Verification
The bench feeds sets that are likely to break a wrongly wired schedule. These include a fully reversed set, an already sorted set, all-equal keys, alternating 0 and maximum keys, heavy duplicates and a lone large key at item 0. A missing or misplaced comparator leaves one of these partly unsorted or duplicates a key. Back-to-back sets mixed with idle gaps expose a valid flag that drifts from its data by a stage, which would show as a wrong latency or a spurious result. Reset is asserted while three sets are in flight. A design that failed to clear a stage's valid flag would then release one of those stale sets after reset.

// File: rtl/oems_pkg.sv
package oems_pkg;

   // Number of comparator levels for 2^p keys.
   function automatic int net_depth(input int p);
      return (p * (p + 1)) / 2;
   endfunction

   // Closed-form comparator count for 2^p keys.
   function automatic int cmp_formula(input int p);
      return (((p * p - p + 4) << p) >> 2) - 1;
   endfunction

   // Half-size of the sorted runs being merged at level lvl.
   function automatic int level_pp(input int lvl);
      int s;
      int rem;
      s   = 1;
      rem = lvl;
      while (rem >= s) begin
         rem = rem - s;
         s   = s + 1;
      end
      return 1 << (s - 1);
   endfunction

   // Wire distance between the two inputs of a comparator at level lvl.
   function automatic int level_k(input int lvl);
      int s;
      int rem;
      s   = 1;
      rem = lvl;
      while (rem >= s) begin
         rem = rem - s;
         s   = s + 1;
      end
      return (1 << (s - 1)) >> rem;
   endfunction

   // True when wire w is the lower input of a comparator reaching wire w+k.
   function automatic bit is_low(input int w, input int pp, input int k, input int n);
      int r;
      if (w < 0 || w + k >= n) return 1'b0;
      r = w - (k % pp);
      if (r < 0) return 1'b0;
      if ((r % (2 * k)) >= k) return 1'b0;
      return (w / (2 * pp)) == ((w + k) / (2 * pp));
   endfunction

   // Comparator count obtained by walking the generated schedule.
   function automatic int cmp_built(input int p);
      int total;
      int n;
      n     = 1 << p;
      total = 0;
      for (int l = 0; l < net_depth(p); l++)
         for (int w = 0; w < n; w++)
            if (is_low(w, level_pp(l), level_k(l), n)) total = total + 1;
      return total;
   endfunction

endpackage

// File: rtl/oems_cmp_xchg.sv
module oems_cmp_xchg #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi
);
   logic swap;

   assign swap = a > b;
   assign lo   = swap ? b : a;
   assign hi   = swap ? a : b;
endmodule

// File: rtl/oems_level.sv
module oems_level
   import oems_pkg::*;
#(
   parameter int N  = 8,
   parameter int W  = 8,
   parameter int PP = 1,
   parameter int K  = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                vld_i,
   input  logic [N-1:0][W-1:0] keys_i,
   output logic                vld_o,
   output logic [N-1:0][W-1:0] keys_o
);
   logic [N-1:0][W-1:0] nxt;

   for (genvar w = 0; w < N; w++) begin : g_wire
      if (is_low(w, PP, K, N)) begin : g_cmp
         oems_cmp_xchg #(.W(W)) u_cx (
            .a  (keys_i[w]),
            .b  (keys_i[w+K]),
            .lo (nxt[w]),
            .hi (nxt[w+K])
         );
      end else if (!is_low(w - K, PP, K, N)) begin : g_pass
         assign nxt[w] = keys_i[w];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   always_ff @(posedge clk) begin
      keys_o <= nxt;
   end
endmodule

// File: rtl/oe_merge_sorter.sv
module oe_merge_sorter
   import oems_pkg::*;
#(
   parameter int P = 3,
   parameter int W = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [(W<<P)-1:0]    in_keys,
   output logic                 out_valid,
   output logic [(W<<P)-1:0]    out_keys
);
   localparam int N     = 1 << P;
   localparam int DEPTH = net_depth(P);
   localparam int NCMP  = cmp_formula(P);

   if (P < 1 || P > 8) begin : g_bad_p
      $error("oe_merge_sorter: P must lie in 1..8");
   end
   if (W < 1) begin : g_bad_w
      $error("oe_merge_sorter: W must be at least 1");
   end
   if (cmp_built(P) != NCMP) begin : g_bad_sched
      $error("oe_merge_sorter: generated schedule has the wrong comparator count");
   end

   logic [N-1:0][W-1:0] st_keys [DEPTH+1];
   logic                st_vld  [DEPTH+1];

   for (genvar i = 0; i < N; i++) begin : g_unpack
      assign st_keys[0][i]              = in_keys[(N-1-i)*W +: W];
      assign out_keys[(N-1-i)*W +: W]   = st_keys[DEPTH][i];
   end
   assign st_vld[0]  = in_valid;
   assign out_valid  = st_vld[DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
      oems_level #(
         .N  (N),
         .W  (W),
         .PP (level_pp(g)),
         .K  (level_k(g))
      ) u_lvl (
         .clk    (clk),
         .rst    (rst),
         .vld_i  (st_vld[g]),
         .keys_i (st_keys[g]),
         .vld_o  (st_vld[g+1]),
         .keys_o (st_keys[g+1])
      );
   end
endmodule

// File: rtl/oems_checker.sv
module oems_checker
   import oems_pkg::*;
#(
   parameter int P = 3,
   parameter int W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [(W<<P)-1:0] in_keys,
   input logic              out_valid,
   input logic [(W<<P)-1:0] out_keys
);
   localparam int N     = 1 << P;
   localparam int DEPTH = net_depth(P);
   localparam int SW    = W + P;

   logic [DEPTH-1:0] vld_sh;
   logic [SW-1:0]    sum_sh [DEPTH];
   logic [SW-1:0]    in_sum;
   logic [SW-1:0]    out_sum;
   logic             ordered;

   always_comb begin
      in_sum  = '0;
      out_sum = '0;
      ordered = 1'b1;
      for (int i = 0; i < N; i++) begin
         in_sum  = in_sum  + SW'(in_keys[(N-1-i)*W +: W]);
         out_sum = out_sum + SW'(out_keys[(N-1-i)*W +: W]);
      end
      for (int i = 0; i < N - 1; i++)
         if (out_keys[(N-1-i)*W +: W] > out_keys[(N-2-i)*W +: W]) ordered = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) vld_sh <= '0;
      else     vld_sh <= {vld_sh[DEPTH-2:0], in_valid};
   end

   always_ff @(posedge clk) begin
      sum_sh[0] <= in_sum;
      for (int i = 1; i < DEPTH; i++) sum_sh[i] <= sum_sh[i-1];
   end

   assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid == vld_sh[DEPTH-1]);

   assert_ascending_R1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ordered);

   assert_keysum_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_sum == sum_sh[DEPTH-1]));

   assert_reset_flush_R5: assert property (@(posedge clk)
      rst |=> !out_valid);
endmodule

bind oe_merge_sorter oems_checker #(.P(P), .W(W)) u_chk (.*);

// File: tb/oe_merge_sorter_bench.sv
module oe_merge_sorter_bench;
   localparam int  P      = 3;
   localparam int  W      = 8;
   localparam int  N      = 1 << P;
   localparam int  DEPTH  = (P * (P + 1)) / 2;
   localparam int  NV     = 8;
   localparam time PERIOD = 10ns;

   localparam logic [63:0] TV_IN [NV] = '{
      64'h42_52_50_66_25_8A_28_96,
      64'h08_07_06_05_04_03_02_01,
      64'h01_02_03_04_05_06_07_08,
      64'h5A_5A_5A_5A_5A_5A_5A_5A,
      64'hFF_00_FF_00_FF_00_FF_00,
      64'h33_11_33_22_11_22_33_11,
      64'hFF_01_01_01_01_01_01_01,
      64'h80_7F_81_7E_01_FE_00_FF
   };
   localparam logic [63:0] TV_EXP [NV] = '{
      64'h25_28_42_50_52_66_8A_96,
      64'h01_02_03_04_05_06_07_08,
      64'h01_02_03_04_05_06_07_08,
      64'h5A_5A_5A_5A_5A_5A_5A_5A,
      64'h00_00_00_00_FF_FF_FF_FF,
      64'h11_11_11_22_22_33_33_33,
      64'h01_01_01_01_01_01_01_FF,
      64'h00_01_7E_7F_80_81_FE_FF
   };
   localparam int GAP [NV] = '{0, 0, 0, 2, 0, 1, 0, 0};

   logic              clk = 1'b0;
   logic              rst;
   logic              in_valid;
   logic [N*W-1:0]    in_keys;
   logic              out_valid;
   logic [N*W-1:0]    out_keys;

   int  checks   = 0;
   int  fails    = 0;
   int  cyc      = 0;
   int  rx       = 0;
   int  sent_cyc [NV];
   bit  collect  = 1'b0;
   bit  done     = 1'b0;

   oe_merge_sorter #(.P(P), .W(W)) u_oe_merge_sorter (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_keys   (in_keys),
      .out_valid (out_valid),
      .out_keys  (out_keys)
   );

   always #(PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Output collector: every valid result is matched to the next table entry.
   always @(negedge clk) begin
      if (collect && out_valid) begin
         if (rx < NV) begin
            // R1 R2 R6 R7: packed sorted keys, item 0 in the top byte
            check(out_keys == TV_EXP[rx], "R1/R2/R6/R7 sorted keys", out_keys, TV_EXP[rx]);
            // R3 R4: exact latency, also for back-to-back sets
            check(cyc - sent_cyc[rx] == DEPTH, "R3/R4 latency",
                  64'(cyc - sent_cyc[rx]), 64'(DEPTH));
         end else begin
            check(1'b0, "R8 spurious output", 64'(rx), 64'(NV));
         end
         rx++;
      end
   end

   initial begin
      rst      = 1'b1;
      in_valid = 1'b0;
      in_keys  = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R5: reset state
      check(out_valid == 1'b0, "R5 valid low after reset", 64'(out_valid), 64'd0);
      collect = 1'b1;

      for (int k = 0; k < NV; k++) begin
         for (int g = 0; g < GAP[k]; g++) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         in_valid    = 1'b1;
         in_keys     = TV_IN[k];
         sent_cyc[k] = cyc;
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (DEPTH + 4) @(negedge clk);
      // R8 R4: exactly one result per accepted set, none for idle cycles
      check(rx == NV, "R8 result count", 64'(rx), 64'(NV));
      collect = 1'b0;

      // R5: reset while three sets are in flight drops them all
      for (int k = 0; k < 3; k++) begin
         in_valid = 1'b1;
         in_keys  = TV_IN[k];
         @(negedge clk);
      end
      in_valid = 1'b0;
      rst      = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R5 valid cleared by reset", 64'(out_valid), 64'd0);
      rst = 1'b0;
      for (int c = 0; c < DEPTH + 2; c++) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R5 in-flight set dropped", 64'(out_valid), 64'd0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(PERIOD * 5000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule